// File: doc/BRIEF.md
# Transmit Lane Start-up Sequencer

This block drives the link-layer octet stream of one transmit lane of a serial converter link during start-up and normal running. It watches an active-low synchronization request from the receiver and a local multiframe clock pulse. From these it steps the lane through three phases. The first is code group synchronization, which sends repeated comma characters. The second is the initial lane alignment sequence, which is four multiframes long and has fixed control characters and a block of link configuration octets. The third is user data, which is passed through from the framer. Every octet leaves with a control-character flag and a valid strobe. The datapath is one octet wide and carries one octet per link clock.

Frame length (octets per frame) and multiframe length (frames per multiframe) are parameters. Lane count, converter count and converter resolution are also parameters, and they only fill the configuration octets. The block does not do 8b/10b encoding, scrambling, serialization or deskew, and it does not generate the multiframe clock. Every output is registered. The octet that the block decides at a rising edge, using the inputs sampled at that edge, is visible on the outputs until the next rising edge.

Top module: `jtx_lane_seq`

## Requirements
- R1: While `sync_ni` is sampled low, the octet produced for that cycle is 0xBC with `k_flag_o` = 1 (K28.5), in every phase.
- R2: While `rst_ni` is low, `octet_o` = 0x00, `k_flag_o` = 0 and `valid_o` = 0. From the first edge after reset is released, `valid_o` is 1 on every cycle.
- R3: The lane alignment sequence starts no sooner than FRAME_OCTETS+9 octets after the first octet that sampled `sync_ni` high. The block ignores any multiframe clock edge that comes sooner and waits for a later one.
- R4: The alignment sequence starts only on a sampled 0-to-1 transition of `lmfc_i`. A pulse that stays high for several cycles triggers the start only once, and only on its first high cycle.
- R5: The alignment sequence lasts exactly 4 x FRAME_OCTETS x FRAMES_PER_MF octets. Position 0 of each multiframe is 0x1C with k = 1 (K28.0), and the last position is 0x7C with k = 1 (K28.3).
- R6: Position 1 of the second alignment multiframe is 0x9C with k = 1 (K28.4).
- R7: Positions 2 to 6 of the second alignment multiframe carry, with k = 0, the values LANES-1, FRAME_OCTETS-1, FRAMES_PER_MF-1, CONVERTERS-1 and RESOLUTION-1, in that order.
- R8: Every other alignment octet, at sequence index i counted from 0, is i mod 256 with k = 0.
- R9: The octet right after the final K28.3 of the sequence carries `data_i` of that cycle with k = 0, and user data goes on every cycle after that.
- R10: When `sync_ni` drops during the alignment sequence or during user data, the block goes back to code group synchronization. Its next alignment start again obeys R3 and R4, counted from the new rise of `sync_ni`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Link clock, one octet per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_ni | input | 1 | Receiver synchronization request, low requests comma characters |
| lmfc_i | input | 1 | Local multiframe clock, rising edge marks a multiframe boundary |
| data_i | input | 8 | User data octet from the framer |
| octet_o | output | 8 | Outgoing octet |
| k_flag_o | output | 1 | Outgoing octet is a control character |
| valid_o | output | 1 | Octet strobe, high every cycle out of reset |

## Verification
The hardest situation to reach is the one where a multiframe clock edge arrives inside the minimum gap after the synchronization request is released, so that it must be skipped. It only happens for certain phases of the `sync_ni` rise relative to the multiframe clock. The bench sweeps every phase of an 8-octet multiframe clock against a fixed rise time. It repeats the sweep with one-cycle and three-cycle wide clock pulses, and it drops `sync_ni` both inside the alignment sequence and inside user data. This makes the block meet both the skipped-edge and the taken-edge cases, for the first start and for a restart.

// File: rtl/jtx_seq_pkg.sv
package jtx_seq_pkg;
  localparam logic [7:0] K28_0 = 8'h1C;
  localparam logic [7:0] K28_3 = 8'h7C;
  localparam logic [7:0] K28_4 = 8'h9C;
  localparam logic [7:0] K28_5 = 8'hBC;

  localparam int unsigned ILAS_MFS = 4;

  typedef enum logic [1:0] {
    ST_CGS  = 2'd0,
    ST_ILAS = 2'd1,
    ST_DATA = 2'd2
  } seq_state_e;
endpackage

// File: rtl/jtx_lane_pos_cnt.sv
module jtx_lane_pos_cnt #(
  parameter int unsigned FRAME_OCTETS  = 2,
  parameter int unsigned FRAMES_PER_MF = 4,
  localparam int unsigned OCT_W = (FRAME_OCTETS > 1) ? $clog2(FRAME_OCTETS) : 1,
  localparam int unsigned FRM_W = (FRAMES_PER_MF > 1) ? $clog2(FRAMES_PER_MF) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             adv_i,
  output logic [OCT_W-1:0] oct_o,
  output logic [FRM_W-1:0] frm_o,
  output logic [1:0]       mf_o,
  output logic             frame_end_o,
  output logic             mf_end_o
);
  logic [OCT_W-1:0] oct_q, oct_n;
  logic [FRM_W-1:0] frm_q, frm_n;
  logic [1:0]       mf_q, mf_n;

  // start_i treats the current octet as position 0
  assign oct_o = start_i ? '0 : oct_q;
  assign frm_o = start_i ? '0 : frm_q;
  assign mf_o  = start_i ? '0 : mf_q;

  assign frame_end_o = (oct_o == OCT_W'(FRAME_OCTETS - 1));
  assign mf_end_o    = frame_end_o && (frm_o == FRM_W'(FRAMES_PER_MF - 1));

  always_comb begin
    oct_n = oct_o;
    frm_n = frm_o;
    mf_n  = mf_o;
    if (start_i || adv_i) begin
      if (frame_end_o) begin
        oct_n = '0;
        if (mf_end_o) begin
          frm_n = '0;
          mf_n  = mf_o + 2'd1;
        end else begin
          frm_n = frm_o + FRM_W'(1);
        end
      end else begin
        oct_n = oct_o + OCT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oct_q <= '0;
      frm_q <= '0;
      mf_q  <= '0;
    end else begin
      oct_q <= oct_n;
      frm_q <= frm_n;
      mf_q  <= mf_n;
    end
  end
endmodule

// File: rtl/jtx_ilas_gen.sv
module jtx_ilas_gen
  import jtx_seq_pkg::*;
#(
  parameter int unsigned FRAME_OCTETS  = 2,
  parameter int unsigned FRAMES_PER_MF = 4,
  parameter int unsigned LANES         = 1,
  parameter int unsigned CONVERTERS    = 2,
  parameter int unsigned RESOLUTION    = 16,
  localparam int unsigned OCT_W = (FRAME_OCTETS > 1) ? $clog2(FRAME_OCTETS) : 1,
  localparam int unsigned FRM_W = (FRAMES_PER_MF > 1) ? $clog2(FRAMES_PER_MF) : 1,
  localparam int unsigned MF_OCTETS = FRAME_OCTETS * FRAMES_PER_MF,
  localparam int unsigned POS_W = $clog2(MF_OCTETS),
  localparam int unsigned IDX_W = POS_W + 2,
  localparam int unsigned RMP_W = (IDX_W > 8) ? IDX_W : 8
) (
  input  logic [OCT_W-1:0] oct_i,
  input  logic [FRM_W-1:0] frm_i,
  input  logic [1:0]       mf_i,
  output logic [7:0]       octet_o,
  output logic             k_o
);
  logic [POS_W-1:0] pos;
  logic [RMP_W-1:0] ramp;

  assign pos  = POS_W'(frm_i) * POS_W'(FRAME_OCTETS) + POS_W'(oct_i);
  assign ramp = RMP_W'(mf_i) * RMP_W'(MF_OCTETS) + RMP_W'(pos);

  always_comb begin
    octet_o = ramp[7:0];
    k_o     = 1'b0;
    if (pos == '0) begin
      octet_o = K28_0;
      k_o     = 1'b1;
    end else if (pos == POS_W'(MF_OCTETS - 1)) begin
      octet_o = K28_3;
      k_o     = 1'b1;
    end else if (mf_i == 2'd1) begin
      case (pos)
        POS_W'(1): begin octet_o = K28_4; k_o = 1'b1; end
        POS_W'(2): octet_o = 8'(LANES - 1);
        POS_W'(3): octet_o = 8'(FRAME_OCTETS - 1);
        POS_W'(4): octet_o = 8'(FRAMES_PER_MF - 1);
        POS_W'(5): octet_o = 8'(CONVERTERS - 1);
        POS_W'(6): octet_o = 8'(RESOLUTION - 1);
        default:   octet_o = ramp[7:0];
      endcase
    end
  end
endmodule

// File: rtl/jtx_lane_seq.sv
module jtx_lane_seq
  import jtx_seq_pkg::*;
#(
  parameter int unsigned FRAME_OCTETS  = 2,
  parameter int unsigned FRAMES_PER_MF = 4,
  parameter int unsigned LANES         = 1,
  parameter int unsigned CONVERTERS    = 2,
  parameter int unsigned RESOLUTION    = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_ni,
  input  logic       lmfc_i,
  input  logic [7:0] data_i,
  output logic [7:0] octet_o,
  output logic       k_flag_o,
  output logic       valid_o
);
  localparam int unsigned OCT_W   = (FRAME_OCTETS > 1) ? $clog2(FRAME_OCTETS) : 1;
  localparam int unsigned FRM_W   = (FRAMES_PER_MF > 1) ? $clog2(FRAMES_PER_MF) : 1;
  localparam int unsigned GAP_MIN = FRAME_OCTETS + 9;
  localparam int unsigned GAP_W   = $clog2(GAP_MIN + 1);

  seq_state_e       st_q, st_n;
  logic             lmfc_q;
  logic             lmfc_edge;
  logic [GAP_W-1:0] gap_q, gap_n;
  logic             cnt_start, cnt_adv;
  logic [OCT_W-1:0] oct;
  logic [FRM_W-1:0] frm;
  logic [1:0]       mf;
  logic             frame_end, mf_end;
  logic [7:0]       ilas_octet;
  logic             ilas_k;
  logic [7:0]       octet_n;
  logic             k_n;

  assign lmfc_edge = lmfc_i & ~lmfc_q;

  jtx_lane_pos_cnt #(
    .FRAME_OCTETS (FRAME_OCTETS),
    .FRAMES_PER_MF(FRAMES_PER_MF)
  ) pos_cnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (cnt_start),
    .adv_i      (cnt_adv),
    .oct_o      (oct),
    .frm_o      (frm),
    .mf_o       (mf),
    .frame_end_o(frame_end),
    .mf_end_o   (mf_end)
  );

  jtx_ilas_gen #(
    .FRAME_OCTETS (FRAME_OCTETS),
    .FRAMES_PER_MF(FRAMES_PER_MF),
    .LANES        (LANES),
    .CONVERTERS   (CONVERTERS),
    .RESOLUTION   (RESOLUTION)
  ) ilas_gen_i (
    .oct_i  (oct),
    .frm_i  (frm),
    .mf_i   (mf),
    .octet_o(ilas_octet),
    .k_o    (ilas_k)
  );

  always_comb begin
    st_n      = st_q;
    gap_n     = gap_q;
    cnt_start = 1'b0;
    cnt_adv   = 1'b0;
    octet_n   = K28_5;
    k_n       = 1'b1;
    if (!sync_ni) begin
      st_n  = ST_CGS;
      gap_n = '0;
    end else begin
      unique case (st_q)
        ST_CGS: begin
          if (lmfc_edge && (gap_q >= GAP_W'(GAP_MIN))) begin
            cnt_start = 1'b1;
            st_n      = ST_ILAS;
            octet_n   = ilas_octet;
            k_n       = ilas_k;
          end else if (gap_q != GAP_W'(GAP_MIN)) begin
            gap_n = gap_q + GAP_W'(1);
          end
        end
        ST_ILAS: begin
          cnt_adv = 1'b1;
          octet_n = ilas_octet;
          k_n     = ilas_k;
          if (mf_end && (mf == 2'(ILAS_MFS - 1))) st_n = ST_DATA;
        end
        ST_DATA: begin
          cnt_adv = 1'b1;
          octet_n = data_i;
          k_n     = 1'b0;
        end
        default: st_n = ST_CGS;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_CGS;
      lmfc_q   <= 1'b0;
      gap_q    <= '0;
      octet_o  <= '0;
      k_flag_o <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      st_q     <= st_n;
      lmfc_q   <= lmfc_i;
      gap_q    <= gap_n;
      octet_o  <= octet_n;
      k_flag_o <= k_n;
      valid_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/jtx_lane_seq_chk.sv
module jtx_lane_seq_chk
  import jtx_seq_pkg::*;
#(
  parameter int unsigned FRAME_OCTETS = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sync_ni,
  input logic       lmfc_i,
  input logic       lmfc_q,
  input logic [7:0] octet_o,
  input logic       k_flag_o
);
  localparam int unsigned GAP_MIN = FRAME_OCTETS + 9;
  localparam int unsigned HC_W    = $clog2(GAP_MIN + 1);

  logic [HC_W-1:0] high_cnt_q;
  logic            ilas_begin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           high_cnt_q <= '0;
    else if (!sync_ni)                     high_cnt_q <= '0;
    else if (high_cnt_q != HC_W'(GAP_MIN)) high_cnt_q <= high_cnt_q + HC_W'(1);
  end

  assign ilas_begin = k_flag_o && (octet_o == K28_0);

  assert_comma_on_sync_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_ni |=> (k_flag_o && octet_o == K28_5));

  assert_min_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ilas_begin && $past(k_flag_o && octet_o == K28_5)) |-> ($past(high_cnt_q) >= HC_W'(GAP_MIN)));

  assert_lmfc_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ilas_begin && $past(k_flag_o && octet_o == K28_5)) |-> $past(lmfc_i && !lmfc_q));

  assert_cfg_after_k284_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_ni && k_flag_o && octet_o == K28_4) |=> !k_flag_o);
endmodule

bind jtx_lane_seq jtx_lane_seq_chk #(
  .FRAME_OCTETS(FRAME_OCTETS)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sync_ni (sync_ni),
  .lmfc_i  (lmfc_i),
  .lmfc_q  (lmfc_q),
  .octet_o (octet_o),
  .k_flag_o(k_flag_o)
);

// File: tb/jtx_lane_seq_tb.sv
module jtx_lane_seq_tb_top;
  localparam int F   = 2;
  localparam int K   = 4;
  localparam int MF  = F * K;
  localparam int L   = 1;
  localparam int M   = 2;
  localparam int N   = 16;
  localparam int GAP = F + 9;
  localparam int CYC = 130;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_ni = 1'b0;
  logic       lmfc_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [7:0] octet_o;
  logic       k_flag_o;
  logic       valid_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  jtx_lane_seq #(
    .FRAME_OCTETS (F),
    .FRAMES_PER_MF(K),
    .LANES        (L),
    .CONVERTERS   (M),
    .RESOLUTION   (N)
  ) dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_ni (sync_ni),
    .lmfc_i  (lmfc_i),
    .data_i  (data_i),
    .octet_o (octet_o),
    .k_flag_o(k_flag_o),
    .valid_o (valid_o)
  );

  task automatic check(input logic [7:0] eo, input logic ek, input logic ev, input string tag);
    n_vec++;
    if (octet_o !== eo || k_flag_o !== ek || valid_o !== ev) begin
      n_bad++;
      $display("FAIL %s: got octet=%h k=%b v=%b, expected octet=%h k=%b v=%b",
               tag, octet_o, k_flag_o, valid_o, eo, ek, ev);
    end
  endtask

  function automatic void ilas_ref(input int i, output logic [7:0] o, output logic k,
                                   output string tag);
    int mf, p;
    int cfg[5];
    cfg = '{L - 1, F - 1, K - 1, M - 1, N - 1};
    mf  = i / MF;
    p   = i % MF;
    k   = 1'b0;
    if (p == 0) begin o = 8'h1C; k = 1'b1; tag = (i == 0) ? "R4" : "R5"; end
    else if (p == MF - 1) begin o = 8'h7C; k = 1'b1; tag = "R5"; end
    else if (mf == 1 && p == 1) begin o = 8'h9C; k = 1'b1; tag = "R6"; end
    else if (mf == 1 && p >= 2 && p <= 6) begin o = 8'(cfg[p - 2]); tag = "R7"; end
    else begin o = 8'(i); tag = "R8"; end
  endfunction

  initial begin
    for (int ph = 0; ph < MF; ph++) begin
      for (int wi = 0; wi < 2; wi++) begin
        for (int mode = 0; mode < 3; mode++) begin
          int st, t0, ts, drop_c, starts, w;
          logic s;
          logic [7:0] eo;
          logic ek;
          string tag;
          w = (wi == 0) ? 1 : 3;
          // R2: reset state
          @(negedge clk_i);
          rst_ni = 1'b0; sync_ni = 1'b0; lmfc_i = 1'b0;
          @(negedge clk_i);
          check(8'h00, 1'b0, 1'b0, "R2");
          rst_ni = 1'b1;
          st = 0; t0 = 0; ts = 0; drop_c = 1 << 20; starts = 0;
          for (int c = 0; c < CYC; c++) begin
            s = (c >= 4) && !(c >= drop_c && c < drop_c + 3);
            sync_ni = s;
            lmfc_i  = (((c + MF - ph) % MF) < w);
            data_i  = 8'((c * 7 + ph * 13 + mode) & 8'hFF);
            if (!s) begin
              st = 0; t0 = c + 1; eo = 8'hBC; ek = 1'b1;
              tag = (starts > 0) ? "R10" : "R1";
            end else if (st == 0) begin
              if ((c % MF) == ph && (c - t0) >= GAP) begin
                st = 1; ts = c; starts++;
                ilas_ref(0, eo, ek, tag);
                tag = (starts > 1) ? "R10" : "R3";
                if (starts == 1 && mode != 0) drop_c = ts + ((mode == 1) ? 5 : 40);
              end else begin
                eo = 8'hBC; ek = 1'b1; tag = "R3";
              end
            end else if (st == 1) begin
              ilas_ref(c - ts, eo, ek, tag);
              if (c - ts == 4 * MF - 1) st = 2;
            end else begin
              eo = data_i; ek = 1'b0; tag = "R9";
            end
            @(negedge clk_i);
            check(eo, ek, 1'b1, tag);
          end
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule